// File: doc/BRIEF.md
# SMM Address Decode and Remap

This block sits on the processor transaction path and makes one routing decision for each request. A request goes either to system DRAM or down to the I/O hub. Three system-management windows can claim a request. The first is a legacy window at A0000h–BFFFFh. The second is a high alias at FEDA0000h–FEDBFFFFh, which is relocated onto the legacy DRAM range. The third is a segment just below top of memory. A window claims a request only when its enable bit is set. Whether a claimed request reaches DRAM then depends on the SMM mode input, the access type (code or data) and two control bits, called open and close.

A second table covers the legacy ROM area from C0000h to FFFFFh, which is split into fixed-size segments. Each segment has two attribute bits, one for reads and one for writes, so the two can be steered separately. Software can set reads to fetch ROM from the hub while writes land in DRAM, and use this to copy ROM into DRAM. Afterwards it can set reads to hit DRAM while writes go elsewhere.

Every decision is registered. It appears one clock after the request, together with a valid strobe and the address to be issued. A separate registered flag reports the illegal case where open and close are both set.

Top module: `smm_addr_router`

## Requirements
- R1: A request presented with `req_valid` high produces `rsp_valid` high exactly one clock later. A cycle without a request produces `rsp_valid` low on the next clock. While no request arrives, `rsp_hub` and `rsp_addr` keep their last values.
- R2: A request with `req_io` high goes to the hub (`rsp_hub`=1) with its address unchanged, whatever the window or shadow settings are.
- R3: A request in A0000h–BFFFFh with `compat_en` set goes to DRAM at the same address when granted (see R6). When not granted, it goes to the hub at the same address.
- R4: A request in FEDA0000h–FEDBFFFFh with `high_en` set is rewritten to (address − FEDA0000h + A0000h) and sent to DRAM when granted. When not granted, it goes to the hub with the address unchanged.
- R5: With `tseg_en` set, a request in [`tom` − `tseg_size`, `tom`) goes to DRAM at the same address when granted, and to the hub when not granted. If `tseg_size` is zero, the segment is empty. If `tseg_size` exceeds `tom`, the segment starts at address 0.
- R6: A window grants DRAM access when `smm_open` is 1. It also grants access when `smm_mode` is 1, except for data accesses (`req_code`=0) while `smm_close` is 1. In every other case it refuses.
- R7: The shadow area C0000h–FFFFFh consists of 16 segments of 16 KiB each, and segment i starts at C0000h + i·4000h. For segment i, `shadow_cfg[2i]`=1 sends reads to DRAM and `shadow_cfg[2i+1]`=1 sends writes to DRAM. A cleared bit sends that access type to the hub. The address is never changed.
- R8: A request that no enabled window and no shadow segment claims goes to DRAM when it is below `tom`, and to the hub otherwise. A disabled window decodes under this rule.
- R9: `cfg_err` is 1 on the clock after a cycle in which `smm_open` and `smm_close` are both 1, and 0 on the clock after any other cycle. It does not depend on requests.
- R10: When several rules claim an address, the first in this order wins: I/O, high window, TSEG window, legacy window, shadow segments, default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Transaction address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_io | input | 1 | 1 = I/O-space access |
| smm_mode | input | 1 | Processor is in system-management mode |
| tom | input | 32 | Top of memory, exclusive |
| tseg_size | input | 32 | Size of the segment below top of memory |
| compat_en | input | 1 | Enable for the legacy window |
| high_en | input | 1 | Enable for the high window |
| tseg_en | input | 1 | Enable for the top-of-memory segment |
| smm_open | input | 1 | Open control: grants window access outside SMM |
| smm_close | input | 1 | Close control: refuses SMM data accesses |
| shadow_cfg | input | 32 | Read and write attribute bits for each shadow segment |
| rsp_valid | output | 1 | Decision strobe |
| rsp_hub | output | 1 | 1 = hub, 0 = DRAM |
| rsp_addr | output | 32 | Address to issue |
| cfg_err | output | 1 | Open and close both set |

## Verification
The assertions are checked on every cycle and cover the following: the one-clock strobe and the hold of the outputs between requests, the forwarding of I/O accesses to the hub with an unchanged address, and the relocation of granted high-window accesses into A0000h–BFFFFh with the offset kept. They also check that unclaimed addresses at or above top of memory go to the hub, and that the configuration-error flag tracks the open and close controls. The directed scenarios cover the rest. These include the grant matrix across SMM mode, open, close and code fetches, and the edges of the window ranges. They also include a segment that saturates at address 0, the separate read and write steering of individual shadow segments, and the priority order between overlapping rules.

// File: rtl/smm_route_pkg.sv
package smm_route_pkg;

  localparam int unsigned ADDR_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;

  // fixed legacy and high windows
  localparam addr_t COMPAT_LO   = 32'h000A_0000;
  localparam addr_t COMPAT_HI   = 32'h000B_FFFF;
  localparam addr_t HIGH_LO     = 32'hFEDA_0000;
  localparam addr_t HIGH_HI     = 32'hFEDB_FFFF;
  localparam addr_t SHADOW_BASE = 32'h000C_0000;

  // which rule claimed a request, highest priority first
  typedef enum logic [2:0] {
    SRC_IO,
    SRC_HIGH,
    SRC_TSEG,
    SRC_COMPAT,
    SRC_SHADOW,
    SRC_DEFAULT
  } src_e;

  typedef struct packed {
    logic  to_hub;
    addr_t addr;
  } route_t;

  // window access grant from mode and control bits
  function automatic logic smm_grant(input logic en, input logic smm,
                                     input logic open, input logic close,
                                     input logic code);
    return en && (open || (smm && (code || !close)));
  endfunction

endpackage

// File: rtl/smm_range_match.sv
module smm_range_match
  import smm_route_pkg::*;
(
  input  logic  active,
  input  addr_t lo,
  input  addr_t hi,
  input  addr_t addr,
  output logic  hit
);

  // inclusive bounds on both ends
  always_comb begin
    hit = active && (addr >= lo) && (addr <= hi);
  end

endmodule

// File: rtl/smm_shadow_lookup.sv
module smm_shadow_lookup
  import smm_route_pkg::*;
#(
  parameter int unsigned NUM_SEG  = 16,
  parameter int unsigned SEG_BITS = 14
) (
  input  addr_t                  addr,
  input  logic                   is_write,
  input  logic [2*NUM_SEG-1:0]   attr,
  output logic                   hit,
  output logic                   to_dram
);

  localparam int unsigned TAG_W = ADDR_W - SEG_BITS;
  localparam logic [TAG_W-1:0] BASE_TAG = SHADOW_BASE[ADDR_W-1:SEG_BITS];

  logic [TAG_W-1:0]   tag;
  logic [NUM_SEG-1:0] seg_hit;
  logic [NUM_SEG-1:0] seg_dram;

  assign tag = addr[ADDR_W-1:SEG_BITS];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam logic [TAG_W-1:0] SEG_TAG = BASE_TAG + TAG_W'(i);
    // even bit steers reads, odd bit steers writes
    assign seg_hit[i]  = (tag == SEG_TAG);
    assign seg_dram[i] = is_write ? attr[2*i+1] : attr[2*i];
  end

  always_comb begin
    hit     = |seg_hit;
    to_dram = |(seg_hit & seg_dram);
  end

endmodule

// File: rtl/smm_route_select.sv
module smm_route_select
  import smm_route_pkg::*;
(
  input  addr_t  addr,
  input  logic   is_code,
  input  logic   is_io,
  input  logic   smm_mode,
  input  logic   smm_open,
  input  logic   smm_close,
  input  logic   compat_en,
  input  logic   high_en,
  input  logic   tseg_en,
  input  logic   compat_hit,
  input  logic   high_hit,
  input  logic   tseg_hit,
  input  logic   shadow_hit,
  input  logic   shadow_dram,
  input  addr_t  tom,
  output route_t decision
);

  src_e  src;
  logic  grant_c;
  logic  grant_h;
  logic  grant_t;
  addr_t remapped;

  always_comb begin
    grant_c  = smm_grant(compat_en, smm_mode, smm_open, smm_close, is_code);
    grant_h  = smm_grant(high_en,   smm_mode, smm_open, smm_close, is_code);
    grant_t  = smm_grant(tseg_en,   smm_mode, smm_open, smm_close, is_code);
    remapped = addr - HIGH_LO + COMPAT_LO;
  end

  // priority: io, high, tseg, compat, shadow, default
  always_comb begin
    if (is_io)                      src = SRC_IO;
    else if (high_hit && high_en)   src = SRC_HIGH;
    else if (tseg_hit && tseg_en)   src = SRC_TSEG;
    else if (compat_hit && compat_en) src = SRC_COMPAT;
    else if (shadow_hit)            src = SRC_SHADOW;
    else                            src = SRC_DEFAULT;
  end

  always_comb begin
    decision.addr   = addr;
    decision.to_hub = 1'b1;
    case (src)
      SRC_IO: begin
        decision.to_hub = 1'b1;
      end
      SRC_HIGH: begin
        decision.to_hub = !grant_h;
        if (grant_h) decision.addr = remapped;
      end
      SRC_TSEG: begin
        decision.to_hub = !grant_t;
      end
      SRC_COMPAT: begin
        decision.to_hub = !grant_c;
      end
      SRC_SHADOW: begin
        decision.to_hub = !shadow_dram;
      end
      default: begin
        decision.to_hub = (addr >= tom);
      end
    endcase
  end

endmodule

// File: rtl/smm_addr_router.sv
module smm_addr_router
  import smm_route_pkg::*;
#(
  parameter int unsigned SHADOW_SEGS     = 16,
  parameter int unsigned SHADOW_SEG_BITS = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [31:0]                req_addr,
  input  logic                       req_write,
  input  logic                       req_code,
  input  logic                       req_io,
  input  logic                       smm_mode,
  input  logic [31:0]                tom,
  input  logic [31:0]                tseg_size,
  input  logic                       compat_en,
  input  logic                       high_en,
  input  logic                       tseg_en,
  input  logic                       smm_open,
  input  logic                       smm_close,
  input  logic [2*SHADOW_SEGS-1:0]   shadow_cfg,
  output logic                       rsp_valid,
  output logic                       rsp_hub,
  output logic [31:0]                rsp_addr,
  output logic                       cfg_err
);

  localparam int unsigned RST_STAGES = 2;

  // reset: asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[RST_STAGES-1];

  // segment below top of memory, saturated at zero
  addr_t tseg_lo;
  addr_t tseg_hi;
  logic  tseg_active;

  always_comb begin
    tseg_lo     = (tseg_size > tom) ? '0 : (tom - tseg_size);
    tseg_hi     = tom - addr_t'(1);
    tseg_active = (tseg_size != '0) && (tom != '0);
  end

  logic compat_hit;
  logic high_hit;
  logic tseg_hit;
  logic shadow_hit;
  logic shadow_dram;

  smm_range_match i_compat_match (
    .active (1'b1),
    .lo     (COMPAT_LO),
    .hi     (COMPAT_HI),
    .addr   (req_addr),
    .hit    (compat_hit)
  );

  smm_range_match i_high_match (
    .active (1'b1),
    .lo     (HIGH_LO),
    .hi     (HIGH_HI),
    .addr   (req_addr),
    .hit    (high_hit)
  );

  smm_range_match i_tseg_match (
    .active (tseg_active),
    .lo     (tseg_lo),
    .hi     (tseg_hi),
    .addr   (req_addr),
    .hit    (tseg_hit)
  );

  smm_shadow_lookup #(
    .NUM_SEG  (SHADOW_SEGS),
    .SEG_BITS (SHADOW_SEG_BITS)
  ) i_shadow (
    .addr     (req_addr),
    .is_write (req_write),
    .attr     (shadow_cfg),
    .hit      (shadow_hit),
    .to_dram  (shadow_dram)
  );

  route_t decision;

  smm_route_select i_select (
    .addr        (req_addr),
    .is_code     (req_code),
    .is_io       (req_io),
    .smm_mode    (smm_mode),
    .smm_open    (smm_open),
    .smm_close   (smm_close),
    .compat_en   (compat_en),
    .high_en     (high_en),
    .tseg_en     (tseg_en),
    .compat_hit  (compat_hit),
    .high_hit    (high_hit),
    .tseg_hit    (tseg_hit),
    .shadow_hit  (shadow_hit),
    .shadow_dram (shadow_dram),
    .tom         (tom),
    .decision    (decision)
  );

  // output state: next-state logic then registers
  route_t route_q, route_d;
  logic   valid_q, valid_d;
  logic   err_q,   err_d;
  logic   route_en;

  always_comb begin
    route_en = req_valid;
    valid_d  = req_valid;
    err_d    = smm_open && smm_close;
    route_d  = route_q;
    if (route_en) route_d = decision;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      route_q <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      route_q <= route_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_hub   = route_q.to_hub;
  assign rsp_addr  = route_q.addr;
  assign cfg_err   = err_q;

endmodule

// File: rtl/smm_addr_router_chk.sv
module smm_addr_router_chk (
  input logic        clk,
  input logic        rst_int_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_code,
  input logic        req_io,
  input logic        smm_mode,
  input logic [31:0] tom,
  input logic        high_en,
  input logic        smm_open,
  input logic        smm_close,
  input logic        rsp_valid,
  input logic        rsp_hub,
  input logic [31:0] rsp_addr,
  input logic        cfg_err
);

  logic in_high;
  logic high_granted;
  assign in_high      = (req_addr >= 32'hFEDA_0000) && (req_addr <= 32'hFEDB_FFFF);
  assign high_granted = high_en && (smm_open || (smm_mode && (req_code || !smm_close)));

  // R1: strobe follows request by one clock
  p_strobe_set_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> rsp_valid);
  p_strobe_clr_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !rsp_valid);

  // R1: outputs hold while idle
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> $stable(rsp_hub) && $stable(rsp_addr));

  // R2: I/O goes to hub unchanged
  p_io_to_hub_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && req_io |=> rsp_hub && (rsp_addr == $past(req_addr)));

  // R4: granted high access lands in legacy range, offset kept
  p_high_remap_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && !req_io && in_high && high_granted |=>
      !rsp_hub && (rsp_addr[31:17] == 15'd5) &&
      (rsp_addr[16:0] == $past(req_addr[16:0])));

  // R8: unclaimed address at or above top of memory goes to hub
  p_above_tom_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && !req_io && !in_high && (req_addr >= tom) &&
      (req_addr >= 32'h0010_0000) |=> rsp_hub);

  // R9: configuration error tracks the controls
  p_cfg_err_set_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    smm_open && smm_close |=> cfg_err);
  p_cfg_err_clr_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(smm_open && smm_close) |=> !cfg_err);

endmodule

bind smm_addr_router smm_addr_router_chk i_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_code  (req_code),
  .req_io    (req_io),
  .smm_mode  (smm_mode),
  .tom       (tom),
  .high_en   (high_en),
  .smm_open  (smm_open),
  .smm_close (smm_close),
  .rsp_valid (rsp_valid),
  .rsp_hub   (rsp_hub),
  .rsp_addr  (rsp_addr),
  .cfg_err   (cfg_err)
);

// File: tb/test_smm_addr_router.sv
`timescale 1ns/1ps
module test_smm_addr_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_code, req_io;
  logic [31:0] req_addr;
  logic        smm_mode, compat_en, high_en, tseg_en, smm_open, smm_close;
  logic [31:0] tom, tseg_size;
  logic [31:0] shadow_cfg;
  logic        rsp_valid, rsp_hub, cfg_err;
  logic [31:0] rsp_addr;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  smm_addr_router i_smm_addr_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_code(req_code), .req_io(req_io),
    .smm_mode(smm_mode), .tom(tom), .tseg_size(tseg_size),
    .compat_en(compat_en), .high_en(high_en), .tseg_en(tseg_en),
    .smm_open(smm_open), .smm_close(smm_close), .shadow_cfg(shadow_cfg),
    .rsp_valid(rsp_valid), .rsp_hub(rsp_hub), .rsp_addr(rsp_addr),
    .cfg_err(cfg_err)
  );

  localparam logic HUB  = 1'b1;
  localparam logic DRAM = 1'b0;

  task automatic note(input string tag, input logic ok, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one request; outputs sampled at the next falling edge
  task automatic send(input logic [31:0] a, input logic wr, input logic code,
                      input logic io);
    @(negedge clk);
    req_addr = a; req_write = wr; req_code = code; req_io = io;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic hub,
                            input logic [31:0] a);
    note(tag, rsp_valid === 1'b1, "valid", 32'(rsp_valid), 32'd1);
    note(tag, rsp_hub === hub, "hub", 32'(rsp_hub), 32'(hub));
    note(tag, rsp_addr === a, "addr", rsp_addr, a);
  endtask

  task automatic mode(input logic smm, input logic open, input logic close);
    smm_mode = smm; smm_open = open; smm_close = close;
  endtask

  task automatic t_reset;
    note("R1", rsp_valid === 1'b0, "reset valid", 32'(rsp_valid), 32'd0);
    note("R1", rsp_addr === 32'd0, "reset addr", rsp_addr, 32'd0);
    note("R9", cfg_err === 1'b0, "reset err", 32'(cfg_err), 32'd0);
  endtask

  task automatic t_io;
    mode(1, 0, 0); compat_en = 1; high_en = 1;
    send(32'h000A_1000, 0, 0, 1); expect_rsp("R2", HUB, 32'h000A_1000);
    send(32'hFEDA_0040, 1, 0, 1); expect_rsp("R10", HUB, 32'hFEDA_0040);
  endtask

  task automatic t_compat;
    compat_en = 1;
    mode(0, 0, 0); send(32'h000A_1234, 0, 0, 0); expect_rsp("R3", HUB,  32'h000A_1234);
    mode(1, 0, 0); send(32'h000A_1234, 0, 0, 0); expect_rsp("R3", DRAM, 32'h000A_1234);
    mode(0, 1, 0); send(32'h000B_FFFF, 1, 0, 0); expect_rsp("R3", DRAM, 32'h000B_FFFF);
    compat_en = 0; mode(0, 0, 0);
    send(32'h000A_0000, 0, 0, 0); expect_rsp("R8", DRAM, 32'h000A_0000);
    compat_en = 1;
  endtask

  task automatic t_grant;
    compat_en = 1;
    mode(1, 0, 1);
    send(32'h000A_0010, 0, 0, 0); expect_rsp("R6", HUB,  32'h000A_0010);
    send(32'h000A_0010, 0, 1, 0); expect_rsp("R6", DRAM, 32'h000A_0010);
    mode(0, 0, 1);
    send(32'h000A_0010, 0, 1, 0); expect_rsp("R6", HUB,  32'h000A_0010);
    mode(0, 0, 0);
  endtask

  task automatic t_high;
    high_en = 1; mode(1, 0, 0);
    send(32'hFEDA_0000, 0, 0, 0); expect_rsp("R4", DRAM, 32'h000A_0000);
    send(32'hFEDB_FFFF, 1, 0, 0); expect_rsp("R4", DRAM, 32'h000B_FFFF);
    send(32'hFEDC_0000, 0, 0, 0); expect_rsp("R4", HUB,  32'hFEDC_0000);
    mode(0, 0, 0);
    send(32'hFEDA_1000, 0, 0, 0); expect_rsp("R4", HUB,  32'hFEDA_1000);
    high_en = 0; mode(1, 0, 0);
    send(32'hFEDA_1000, 0, 0, 0); expect_rsp("R8", HUB,  32'hFEDA_1000);
    mode(0, 0, 0);
  endtask

  task automatic t_tseg;
    tom = 32'h1000_0000; tseg_size = 32'h0010_0000; tseg_en = 1;
    mode(1, 0, 0); send(32'h0FF0_0000, 0, 0, 0); expect_rsp("R5", DRAM, 32'h0FF0_0000);
    mode(0, 0, 0); send(32'h0FF0_0010, 0, 0, 0); expect_rsp("R5", HUB,  32'h0FF0_0010);
    send(32'h0FFF_FFFF, 1, 0, 0); expect_rsp("R5", HUB,  32'h0FFF_FFFF);
    send(32'h0FEF_FFFF, 1, 0, 0); expect_rsp("R5", DRAM, 32'h0FEF_FFFF);
    tseg_en = 0;
    send(32'h0FF0_0010, 0, 0, 0); expect_rsp("R8", DRAM, 32'h0FF0_0010);
    // segment larger than memory starts at zero
    tom = 32'h0010_0000; tseg_size = 32'h0020_0000; tseg_en = 1;
    send(32'h0000_1000, 0, 0, 0); expect_rsp("R5", HUB, 32'h0000_1000);
    tseg_size = 32'd0;
    send(32'h0000_1000, 0, 0, 0); expect_rsp("R5", DRAM, 32'h0000_1000);
    tseg_en = 0; tom = 32'h1000_0000; tseg_size = 32'h0010_0000;
  endtask

  task automatic t_shadow;
    mode(0, 0, 0);
    // seg0 = write-DRAM/read-hub, seg1 = read-DRAM, seg15 = both DRAM
    shadow_cfg = 32'hC000_0006;
    send(32'h000C_0000, 0, 0, 0); expect_rsp("R7", HUB,  32'h000C_0000);
    send(32'h000C_0010, 1, 0, 0); expect_rsp("R7", DRAM, 32'h000C_0010);
    send(32'h000C_4000, 0, 0, 0); expect_rsp("R7", DRAM, 32'h000C_4000);
    send(32'h000C_7FFC, 1, 0, 0); expect_rsp("R7", HUB,  32'h000C_7FFC);
    send(32'h000C_8000, 0, 0, 0); expect_rsp("R7", HUB,  32'h000C_8000);
    send(32'h000F_FFF0, 0, 0, 0); expect_rsp("R7", DRAM, 32'h000F_FFF0);
    send(32'h000F_C000, 1, 0, 0); expect_rsp("R7", DRAM, 32'h000F_C000);
    shadow_cfg = 32'h0000_0001;
    send(32'h000C_0000, 0, 0, 0); expect_rsp("R7", DRAM, 32'h000C_0000);
    send(32'h000C_0000, 1, 0, 0); expect_rsp("R7", HUB,  32'h000C_0000);
    shadow_cfg = '0;
  endtask

  task automatic t_default;
    mode(0, 0, 0);
    send(32'h0020_0000, 0, 0, 0); expect_rsp("R8", DRAM, 32'h0020_0000);
    send(32'h2000_0000, 1, 0, 0); expect_rsp("R8", HUB,  32'h2000_0000);
  endtask

  task automatic t_priority;
    // tseg covering shadow area beats shadow attributes
    tom = 32'h0010_0000; tseg_size = 32'h0004_0000; tseg_en = 1; shadow_cfg = '0;
    mode(1, 0, 0); send(32'h000C_0100, 0, 0, 0); expect_rsp("R10", DRAM, 32'h000C_0100);
    // high window beats an overlapping tseg
    tom = 32'hFF00_0000; tseg_size = 32'h0040_0000; high_en = 1;
    send(32'hFEDA_0010, 0, 0, 0); expect_rsp("R10", DRAM, 32'h000A_0010);
    high_en = 0;
    send(32'hFEDA_0010, 0, 0, 0); expect_rsp("R10", DRAM, 32'hFEDA_0010);
    tseg_en = 0; tom = 32'h1000_0000; tseg_size = 32'h0010_0000; mode(0, 0, 0);
  endtask

  task automatic t_hold;
    logic        h;
    logic [31:0] a;
    send(32'h2000_0040, 0, 0, 0);
    h = rsp_hub; a = rsp_addr;
    repeat (3) @(negedge clk);
    note("R1", rsp_valid === 1'b0, "idle valid", 32'(rsp_valid), 32'd0);
    note("R1", rsp_hub === h, "idle hub", 32'(rsp_hub), 32'(h));
    note("R1", rsp_addr === a, "idle addr", rsp_addr, a);
  endtask

  task automatic t_cfg_err;
    @(negedge clk); mode(0, 1, 1);
    @(negedge clk);
    note("R9", cfg_err === 1'b1, "err set", 32'(cfg_err), 32'd1);
    mode(0, 0, 1);
    @(negedge clk);
    note("R9", cfg_err === 1'b0, "err clear", 32'(cfg_err), 32'd0);
    mode(0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_write = 0; req_code = 0;
    req_io = 0; tom = 32'h1000_0000; tseg_size = 32'h0010_0000;
    compat_en = 0; high_en = 0; tseg_en = 0; shadow_cfg = '0;
    mode(0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_io();
    t_compat();
    t_grant();
    t_high();
    t_tseg();
    t_shadow();
    t_default();
    t_priority();
    t_hold();
    t_cfg_err();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule